// File: doc/BRIEF.md
# Capture/Compare Timer with Prescaled Counter

A timer peripheral that derives a 16-bit free-running count from the system clock through a power-of-two prescaler. A set of channels shares that count. Each channel works either as an input capture, which records the count when a selected edge arrives on its pin, or as an output compare, which raises an event when the count reaches a programmed value and then drives its output pin. A separate 16-bit pulse accumulator counts edges of one extra input. Its polarity is programmable, and it either saturates or wraps at the top of its range.

Software reaches all state through a flat register port. A write takes effect at the clock edge on which `wr_en` is high. Reads are combinational from `addr`. Every event sets a flag that is cleared by writing a one to it. Each channel flag, and the wrap flag, drives an interrupt request when its enable bit is set.

Register map (word addresses): 0 control {bit0 run, bits3:1 prescale exponent p, bit4 accumulator enable, bit5 accumulator falling-edge select, bit6 accumulator saturate}; 1 mode (bit i set = channel i compare); 2 edge/action select (two bits per channel, channel i at bits 2i+1:2i); 3 flags (bit i channel, bit 15 wrap); 4 interrupt enables (same layout as the flags); 5 count (write loads the count); 6 accumulator (write loads it); 8+i channel i value.

Top module: `capcmp_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and all compare outputs and interrupt requests are 0.
- R2: With run=1 and exponent p, the count advances once every 2^p clocks. A control write restarts the prescale phase, so k clocks after that write the count has risen by floor(k/2^p).
- R3: With run=0 the count holds its value. A write to address 5 loads the count, and the loaded value reads back.
- R4: When the count steps from 0xFFFF to 0x0000, the wrap flag (flags bit 15) becomes set on that same edge.
- R5: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R6: A compare channel sets its flag one clock after the count first shows its value. The event fires once per arrival of the count at that value, even when the prescaler holds the count for many clocks.
- R7: On a compare event, the output follows the channel's 2-bit action code: 00 leave, 01 set, 10 clear, 11 toggle.
- R8: A capture channel latches the count present in the clock during which its input changes. Code 01 selects rising edges, 10 falling, 11 both, and 00 disables capture.
- R9: Every capture event sets the channel flag. A capture channel whose select is 00 never sets its flag.
- R10: With enable set, the accumulator adds one per rising edge of its input, or per falling edge when bit 5 is set. With enable clear, edges are ignored.
- R11: At 0xFFFF the accumulator holds when bit 6 is set and wraps to 0 when it is clear.
- R12: Channel interrupt i equals flag i AND enable i. The wrap interrupt equals flags bit 15 AND enables bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| cap_in | input | 8 | Channel capture inputs |
| pacc_in | input | 1 | Pulse accumulator input |
| cmp_out | output | 8 | Channel compare outputs |
| ch_irq | output | 8 | Channel interrupt requests |
| ovf_irq | output | 1 | Counter wrap interrupt request |

## Verification
The prescaler is swept over all eight exponents with one fixed run length, so every division ratio gives a distinct expected count. Compare channels are given staggered match values and then tried with each action code, including a mix of codes across channels. A slow-prescale toggle pass separates a single event per arrival from an event on every clock the count stays at the value. Capture uses one rising and one falling edge on all channels at once, with the count read in the same cycle, which separates the rising, falling, both and disabled selects. The accumulator is driven with pulse trains under each polarity, both overflow policies and the disabled setting.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the capture/compare timer: action codes and
// register word addresses. Assumes a 4-bit word address space.
package timer_pkg;
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TOG  = 2'b11
    } cmp_act_e;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_MODE  = 4'd1;
    localparam logic [3:0] A_SEL   = 4'd2;
    localparam logic [3:0] A_FLAG  = 4'd3;
    localparam logic [3:0] A_IEN   = 4'd4;
    localparam logic [3:0] A_COUNT = 4'd5;
    localparam logic [3:0] A_PACC  = 4'd6;
endpackage

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
// Prescaled free-running counter. Divides the clock by 2^pexp, steps the
// count on each prescale tick, flags the wrap and reports a step one cycle
// later. Assumes load is used while stopped; a load cancels that cycle's step.
module timer_counter #(
    parameter int CW = 16,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] pexp,
    input  logic          pre_clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          stepped,
    output logic          ovf_evt
);
    localparam int PRE_W = (1 << PW) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;
    logic             tick;

    // Mask of prescale bits that must all be one for a tick.
    always_comb begin
        one_sh = {{PRE_W{1'b0}}, 1'b1} << pexp;
        mask   = one_sh[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
        tick   = run && ((pre_q | ~mask) == {PRE_W{1'b1}});
    end

    assign ovf_evt = tick && !load && (cnt == {CW{1'b1}});

    // Prescale phase counter, restarted on control write or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || pre_clr || !run) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end

    // Main count with load and prescaled step; step marker for compares.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            stepped <= 1'b0;
        end else begin
            stepped <= tick && !load;
            if (load)      cnt <= load_val;
            else if (tick) cnt <= cnt + 1'b1;
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt == '0));
endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
// One timer channel: input capture or output compare against the shared
// count, with its own write-one-to-clear flag. Assumes cap_in is already
// synchronous to clk.
module timer_channel
    import timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_cmp,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] cnt,
    input  logic          stepped,
    input  logic          cap_in,
    input  logic          wr_val,
    input  logic [CW-1:0] wr_data,
    input  logic          flag_clr,
    output logic          flag,
    output logic [CW-1:0] value,
    output logic          out
);
    logic cap_d, rise, fall, cap_evt, cmp_evt;

    assign rise    = cap_in && !cap_d;
    assign fall    = !cap_in && cap_d;
    assign cap_evt = !is_cmp && ((sel[0] && rise) || (sel[1] && fall));
    assign cmp_evt = is_cmp && stepped && (cnt == value);

    // Delayed input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_d <= 1'b0;
        else        cap_d <= cap_in;
    end

    // Value register: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (cap_evt) value <= cnt;
        else if (wr_val)  value <= wr_data;
    end

    // Event flag: a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (cap_evt || cmp_evt) flag <= 1'b1;
        else if (flag_clr)           flag <= 1'b0;
    end

    // Compare output action.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else if (cmp_evt) begin
            case (cmp_act_e'(sel))
                ACT_SET:  out <= 1'b1;
                ACT_CLR:  out <= 1'b0;
                ACT_TOG:  out <= !out;
                default:  out <= out;
            endcase
        end
    end

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (value == $past(cnt)));
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || cmp_evt) |=> flag);
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && sel == 2'b11) |=> (out != $past(out)));
endmodule

// File: rtl/pulse_accum.sv
`timescale 1ns/1ps
// Edge-counting pulse accumulator with selectable polarity and a choice of
// saturation or wrap at full scale. Assumes pin is synchronous to clk.
module pulse_accum #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fall_sel,
    input  logic          sat,
    input  logic          pin,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] acc
);
    logic pin_d, edge_hit;

    assign edge_hit = fall_sel ? (!pin && pin_d) : (pin && !pin_d);

    // Delayed input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin;
    end

    // Accumulate active edges, holding at full scale in saturate mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc <= '0;
        else if (load)              acc <= load_val;
        else if (en && edge_hit) begin
            if (!(sat && acc == {CW{1'b1}})) acc <= acc + 1'b1;
        end
    end

    assert_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !load && acc == {CW{1'b1}}) |=> (acc == {CW{1'b1}}));
endmodule

// File: rtl/capcmp_timer.sv
`timescale 1ns/1ps
// Capture/compare timer top: register port, shared prescaled counter,
// NCH channels, pulse accumulator, flags and interrupt requests.
// Assumes NCH <= 2^(AW-1) and 2*NCH <= CW; inputs are synchronous.
module capcmp_timer
    import timer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int PW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    input  logic [NCH-1:0] cap_in,
    input  logic           pacc_in,
    output logic [NCH-1:0] cmp_out,
    output logic [NCH-1:0] ch_irq,
    output logic           ovf_irq
);
    localparam int CTRL_W  = PW + 4;
    localparam int B_PEN   = PW + 1;
    localparam int B_PFALL = PW + 2;
    localparam int B_PSAT  = PW + 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NCH-1:0]    mode_q, ien_q, ch_flag;
    logic [2*NCH-1:0]  sel_q;
    logic              ovf_ien_q, ovf_flag;
    logic [CW-1:0]     cnt, acc;
    logic              stepped, ovf_evt;
    logic [CW-1:0]     ch_val [NCH];
    logic [AW-2:0]     ch_idx;
    logic              wr_ctrl, wr_flag;

    assign ch_idx  = addr[AW-2:0];
    assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
    assign wr_flag = wr_en && (addr == AW'(A_FLAG));

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mode_q    <= '0;
            sel_q     <= '0;
            ien_q     <= '0;
            ovf_ien_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                AW'(A_CTRL): ctrl_q <= wdata[CTRL_W-1:0];
                AW'(A_MODE): mode_q <= wdata[NCH-1:0];
                AW'(A_SEL):  sel_q  <= wdata[2*NCH-1:0];
                AW'(A_IEN): begin
                    ien_q     <= wdata[NCH-1:0];
                    ovf_ien_q <= wdata[CW-1];
                end
                default: ;
            endcase
        end
    end

    // Counter wrap flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_flag <= 1'b0;
        else if (ovf_evt)                ovf_flag <= 1'b1;
        else if (wr_flag && wdata[CW-1]) ovf_flag <= 1'b0;
    end

    timer_counter #(.CW(CW), .PW(PW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .pexp(ctrl_q[PW:1]),
        .pre_clr(wr_ctrl), .load(wr_en && (addr == AW'(A_COUNT))),
        .load_val(wdata), .cnt(cnt), .stepped(stepped), .ovf_evt(ovf_evt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        timer_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .is_cmp(mode_q[i]),
            .sel(sel_q[2*i+1:2*i]), .cnt(cnt), .stepped(stepped),
            .cap_in(cap_in[i]),
            .wr_val(wr_en && addr[AW-1] && (ch_idx == (AW-1)'(i))),
            .wr_data(wdata), .flag_clr(wr_flag && wdata[i]),
            .flag(ch_flag[i]), .value(ch_val[i]), .out(cmp_out[i])
        );
    end

    pulse_accum #(.CW(CW)) u_pacc (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_PEN]),
        .fall_sel(ctrl_q[B_PFALL]), .sat(ctrl_q[B_PSAT]), .pin(pacc_in),
        .load(wr_en && (addr == AW'(A_PACC))), .load_val(wdata), .acc(acc)
    );

    assign ch_irq  = ch_flag & ien_q;
    assign ovf_irq = ovf_flag && ovf_ien_q;

    // Combinational read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr[AW-1]) begin
            if (int'(ch_idx) < NCH) rdata = ch_val[ch_idx];
        end else begin
            case (addr)
                AW'(A_CTRL):  rdata[CTRL_W-1:0] = ctrl_q;
                AW'(A_MODE):  rdata[NCH-1:0]    = mode_q;
                AW'(A_SEL):   rdata[2*NCH-1:0]  = sel_q;
                AW'(A_FLAG): begin
                    rdata[NCH-1:0] = ch_flag;
                    rdata[CW-1]    = ovf_flag;
                end
                AW'(A_IEN): begin
                    rdata[NCH-1:0] = ien_q;
                    rdata[CW-1]    = ovf_ien_q;
                end
                AW'(A_COUNT): rdata = cnt;
                AW'(A_PACC):  rdata = acc;
                default:      rdata = '0;
            endcase
        end
    end

    assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
endmodule

// File: tb/tb_capcmp_timer.sv
`timescale 1ns/1ps
module tb_capcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  cap_in = '0;
    logic        pacc_in = 1'b0;
    logic [7:0]  cmp_out, ch_irq;
    logic        ovf_irq;

    int checks = 0;
    int errors = 0;

    capcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .pacc_in(pacc_in),
        .cmp_out(cmp_out), .ch_irq(ch_irq), .ovf_irq(ovf_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #2;
        v = rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pacc_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pacc_in = 1'b1;
            @(negedge clk); pacc_in = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, cap_a, cap_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 16; a++) begin
            peek(4'(a), v);
            chk("R1 reset register", v, 16'h0000);
        end
        chk("R1 reset cmp_out", {8'h00, cmp_out}, 16'h0000);
        chk("R1 reset irq", {7'h00, ovf_irq, ch_irq}, 16'h0000);

        // R2: prescaler sweep over all exponents
        for (int p = 0; p < 8; p++) begin
            wr(4'd0, 16'h0000);
            wr(4'd5, 16'h0000);
            wr(4'd0, 16'(1 | (p << 1)));
            edges(300);
            peek(4'd5, v);
            chk("R2 prescaled count", v, 16'(300 >> p));
        end

        // R3: stop holds, load reads back
        wr(4'd0, 16'h0000);
        peek(4'd5, cap_a);
        edges(20);
        peek(4'd5, v);
        chk("R3 stopped count holds", v, cap_a);
        wr(4'd5, 16'h1234);
        edges(10);
        peek(4'd5, v);
        chk("R3 loaded count", v, 16'h1234);

        // R4 / R12: wrap flag timing and interrupt
        wr(4'd3, 16'hFFFF);
        wr(4'd5, 16'hFFFE);
        wr(4'd4, 16'h8000);
        wr(4'd0, 16'h0001);
        edges(1);
        peek(4'd3, v);
        chk("R4 no wrap flag before wrap", v, 16'h0000);
        edges(1);
        peek(4'd3, v);
        chk("R4 wrap flag set", v, 16'h8000);
        chk("R12 wrap irq", {15'h0, ovf_irq}, 16'h0001);
        // R5: zero write keeps, one write clears
        wr(4'd3, 16'h0000);
        peek(4'd3, v);
        chk("R5 zero write keeps flag", v, 16'h8000);
        wr(4'd3, 16'h8000);
        peek(4'd3, v);
        chk("R5 one write clears flag", v, 16'h0000);
        chk("R12 wrap irq cleared", {15'h0, ovf_irq}, 16'h0000);
        wr(4'd4, 16'h0000);

        // R6 / R7: compare, toggle action, staggered values
        wr(4'd0, 16'h0000);
        wr(4'd5, 16'h0000);
        wr(4'd3, 16'hFFFF);
        wr(4'd1, 16'h00FF);
        wr(4'd2, 16'hFFFF);
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 16'(3 + 2 * i));
        wr(4'd0, 16'h0001);
        edges(3);
        peek(4'd3, v);
        chk("R6 no flag while count reaches value", v, 16'h0000);
        edges(1);
        peek(4'd3, v);
        chk("R6 flag one clock after match", v, 16'h0001);
        edges(26);
        peek(4'd3, v);
        chk("R6 all compare flags", v, 16'h00FF);
        chk("R7 toggle outputs", {8'h00, cmp_out}, 16'h00FF);
        wr(4'd3, 16'h000F);
        peek(4'd3, v);
        chk("R5 partial clear of channel flags", v, 16'h00F0);

        // R7: clear action
        wr(4'd0, 16'h0000);
        wr(4'd5, 16'h0000);
        wr(4'd3, 16'hFFFF);
        wr(4'd2, 16'hAAAA);
        wr(4'd0, 16'h0001);
        edges(30);
        chk("R7 clear outputs", {8'h00, cmp_out}, 16'h0000);

        // R7: mixed actions none/set/clear/toggle by channel index mod 4
        wr(4'd0, 16'h0000);
        wr(4'd5, 16'h0000);
        wr(4'd3, 16'hFFFF);
        wr(4'd2, 16'hE4E4);
        wr(4'd0, 16'h0001);
        edges(30);
        chk("R7 mixed actions", {8'h00, cmp_out}, 16'h00AA);
        peek(4'd3, v);
        chk("R6 flags set for no-action channels", v, 16'h00FF);
        wr(4'd4, 16'h0005);
        chk("R12 channel irq mask", {8'h00, ch_irq}, 16'h0005);
        wr(4'd4, 16'h0000);

        // R6: single toggle per arrival under prescale 8
        wr(4'd0, 16'h0000);
        wr(4'd5, 16'h0000);
        wr(4'd3, 16'hFFFF);
        wr(4'd2, 16'hFFFF);
        wr(4'd0, 16'h0007);
        edges(200);
        chk("R6 one event per arrival", {8'h00, cmp_out}, 16'h0055);

        // R8 / R9: capture with select = channel index mod 4
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'h0000);
        wr(4'd2, 16'hE4E4);
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 16'h0000);
        wr(4'd3, 16'hFFFF);
        wr(4'd5, 16'd100);
        wr(4'd0, 16'h0001);
        edges(5);
        peek(4'd5, cap_a);
        cap_in = 8'hFF;
        edges(3);
        peek(4'd3, v);
        chk("R9 flags after rising edge", v, 16'h00AA);
        peek(4'd9, v);
        chk("R8 rising capture", v, cap_a);
        peek(4'd11, v);
        chk("R8 both-edge capture on rise", v, cap_a);
        peek(4'd10, v);
        chk("R8 falling select ignores rise", v, 16'h0000);
        edges(4);
        peek(4'd5, cap_b);
        cap_in = 8'h00;
        edges(3);
        peek(4'd3, v);
        chk("R9 flags after falling edge", v, 16'h00EE);
        peek(4'd10, v);
        chk("R8 falling capture", v, cap_b);
        peek(4'd11, v);
        chk("R8 both-edge capture on fall", v, cap_b);
        peek(4'd9, v);
        chk("R8 rising select ignores fall", v, cap_a);
        peek(4'd8, v);
        chk("R8 disabled select captures nothing", v, 16'h0000);

        // R10: accumulator polarity and enable
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'h0000);
        wr(4'd0, 16'h0010);
        pacc_pulse(10);
        peek(4'd6, v);
        chk("R10 rising edges counted", v, 16'd10);
        wr(4'd0, 16'h0000);
        pacc_pulse(5);
        peek(4'd6, v);
        chk("R10 disabled ignores edges", v, 16'd10);
        wr(4'd0, 16'h0030);
        @(negedge clk); pacc_in = 1'b1;
        edges(2);
        peek(4'd6, v);
        chk("R10 falling select ignores rise", v, 16'd10);
        pacc_in = 1'b0;
        edges(2);
        peek(4'd6, v);
        chk("R10 falling edge counted", v, 16'd11);

        // R11: saturate and wrap
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'hFFFE);
        wr(4'd0, 16'h0050);
        pacc_pulse(3);
        peek(4'd6, v);
        chk("R11 saturate at full scale", v, 16'hFFFF);
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'hFFFE);
        wr(4'd0, 16'h0010);
        pacc_pulse(3);
        peek(4'd6, v);
        chk("R11 wrap past full scale", v, 16'h0001);

        finish_run();
    end
endmodule